// File: doc/BRIEF.md
# BCD Calendar Clock Register File

This block keeps wall-clock time and date as one BCD digit per 4-bit register, on a small parallel bus with a 4-bit address, a 4-bit data path, and separate read and write strobes. A 32.768 kHz clock-enable input is divided down to a tick every tenth of a second. Each tick steps a cascade of counters: tenths, seconds, minutes, hours in 12- or 24-hour form, day of month, month, two-digit year and weekday. A periodic interrupt raises an output at a chosen interval.

Software stops the clock, loads the digits and the setting register, and restarts it through the control register. When it reads the time it reads the digits one by one. It then reads the control register. If the data-changed flag is set, a tick landed during the sequence and the read is repeated. That same control read clears the flag and acknowledges the interrupt. Address F is shared: a select bit in the control register routes it either to the interrupt-interval register or to the setting register, which holds the hour mode and a two-bit leap-year phase.

The run state is a two-state machine. In CLK_HALTED, time registers accept writes and no ticks occur. A control write with the stop bit clear moves it to CLK_RUNNING, and that transition clears the tenths digit and the prescaler. In CLK_RUNNING, ticks advance the counters and time writes are dropped. A control write with the stop bit set returns it to CLK_HALTED.

Top module: `rtc_regfile`

## Requirements
- R1: After reset the clock is in CLK_HALTED and reads 00:00:00.0, day 01, month 01, year 00 and weekday 1. The setting register reads 1 (24-hour mode, leap phase 00), the control register reads 0 and `irq` is low.
- R2: A read at address 0 returns the data-changed flag in bit 3, with bits 2:0 reading 0. The flag is set by every tenth tick and cleared by the control read. If a tick falls in the same cycle as the control read, the flag stays set.
- R3: A write at address 0 takes bit 3 as test mode, bit 2 as stop, bit 1 as interrupt-register select and bit 0 as interrupt stop. Moving from CLK_HALTED to CLK_RUNNING resets the tenths digit and the prescaler to 0.
- R4: Address F reads and writes the interrupt-interval code when the select bit is 1, and the setting register when it is 0. A write through one view leaves the other unchanged.
- R5: Setting register bit 0 = 1 selects 24-hour mode and bits 3:2 hold the leap-year phase; bit 1 reads 0. Phase 00 is a leap year.
- R6: Time digits (addresses 2 to E) are written only in CLK_HALTED. Writes to address 1 (tenths) are ignored. A write of a value above 9 to a units digit or a year digit is ignored. Tens writes keep only their field: 3 bits for seconds and minutes, bits 1:0 for hours in 24-hour mode, bits 3 and 0 for hours in 12-hour mode, 2 bits for days, 1 bit for months, and 3 bits for the weekday.
- R7: In normal mode a tenth tick occurs on every TENTH_DIV-th clock-enable pulse counted from the start. In test mode every enable pulse is a tick. No tick occurs while halted.
- R8: Tenths wrap 9 to 0 and carry into seconds. Seconds and minutes wrap 59 to 00 and carry. In 24-hour mode hours wrap 23 to 00 and carry into the day.
- R9: In 12-hour mode, bit 3 of the hours-tens register is PM. Going from 11 to 12 toggles PM, 12 goes to 01 with PM unchanged, and only 11 PM to 12 AM carries into the day.
- R10: The day wraps to 01 after the month's last day: 30 for months 4, 6, 9 and 11, 31 for the other months, and 29 for February when the leap phase is 00 and 28 otherwise. Months wrap 12 to 01 and carry into the year.
- R11: The year counts 00 to 99 and wraps. Each year increment advances the leap phase by one, modulo 4. The weekday counts 1 to 7 and steps once on every day rollover.
- R12: Interval codes 1 to 7 give 0.1, 0.5, 1, 5, 10, 30 and 60 s. Code 0 or the interrupt-stop bit disables the interval counter, and a code write restarts the count. `irq` rises on the tick that ends the interval and stays high until a control read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle enable at the 32.768 kHz rate |
| addr | input | 4 | Register address |
| wdata | input | 4 | Write data |
| wr | input | 1 | Write strobe, one cycle per access |
| rd | input | 1 | Read strobe; side effects on control reads |
| rdata | output | 4 | Read data for `addr`, combinational |
| irq | output | 1 | Periodic interrupt, held until a control read |

## Verification
Every cycle, the assertions check the coupling between the prescaler, the run-state machine and the status logic. No tick is produced while halted. A tick always leaves the data-changed flag set, even against a simultaneous control read. A control read without a tick clears the flag. A raised interrupt holds until acknowledged and rises only on a tick. Calendar arithmetic is shown only by the bench scenarios. These cover the leap and common-year end of February, the year and month wrap with leap-phase advance, the three 12-hour transitions, and write masking and write rejection. They also cover the retry case, where a tick between digit reads shows up in the next control read, and the interval and disable behaviour of the interrupt.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [0:0] {
        CLK_HALTED  = 1'b0,
        CLK_RUNNING = 1'b1
    } clk_state_t;

    localparam logic [3:0] A_CTRL  = 4'h0;
    localparam logic [3:0] A_TENTH = 4'h1;
    localparam logic [3:0] A_SEC_U = 4'h2;
    localparam logic [3:0] A_SEC_T = 4'h3;
    localparam logic [3:0] A_MIN_U = 4'h4;
    localparam logic [3:0] A_MIN_T = 4'h5;
    localparam logic [3:0] A_HR_U  = 4'h6;
    localparam logic [3:0] A_HR_T  = 4'h7;
    localparam logic [3:0] A_DAY_U = 4'h8;
    localparam logic [3:0] A_DAY_T = 4'h9;
    localparam logic [3:0] A_MON_U = 4'hA;
    localparam logic [3:0] A_MON_T = 4'hB;
    localparam logic [3:0] A_YR_U  = 4'hC;
    localparam logic [3:0] A_YR_T  = 4'hD;
    localparam logic [3:0] A_WDAY  = 4'hE;
    localparam logic [3:0] A_SHARE = 4'hF;

    // interval in tenth ticks for each interrupt code
    function automatic logic [9:0] irq_interval(input logic [2:0] code);
        case (code)
            3'd1:    return 10'd1;
            3'd2:    return 10'd5;
            3'd3:    return 10'd10;
            3'd4:    return 10'd50;
            3'd5:    return 10'd100;
            3'd6:    return 10'd300;
            3'd7:    return 10'd600;
            default: return 10'd0;
        endcase
    endfunction

    function automatic logic [5:0] month_len(input logic [4:0] mon, input logic is_leap);
        case (mon)
            5'd2:                   return is_leap ? 6'd29 : 6'd28;
            5'd4, 5'd6, 5'd9, 5'd11: return 6'd30;
            default:                return 6'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int TENTH_DIV = 3277
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    input  logic run,
    input  logic test,
    input  logic clr,
    output logic tenth
);
    localparam int CW = (TENTH_DIV > 2) ? $clog2(TENTH_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TENTH_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tenth = run && tick_in && (test || cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (run && tick_in && !test) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tenth,
    input  logic       clr_tenths,
    input  logic       wr_time,
    input  logic       wr_set,
    input  logic [3:0] waddr,
    input  logic [3:0] wdata,
    input  logic [3:0] raddr,
    output logic [3:0] rdata
);
    logic [3:0] ten_q, sec_u, min_u, hr_u, hr_t, day_u, mon_u, yr_u, yr_t;
    logic [2:0] sec_t, min_t, wday;
    logic [1:0] day_t, leap;
    logic       mon_t, mode24;

    logic c_ten, c_sec, c_min, c_hr, c_day, c_mon;
    logic h_last24, h11, h12, h09, day_last, digit_ok;
    logic [5:0] day_bin;
    logic [4:0] mon_bin;

    always_comb begin
        day_bin  = 6'(day_t) * 6'd10 + 6'(day_u);
        mon_bin  = mon_t ? 5'd10 + 5'(mon_u) : 5'(mon_u);
        day_last = (day_bin == month_len(mon_bin, leap == 2'b00));
        h_last24 = (hr_t[1:0] == 2'd2) && (hr_u == 4'd3);
        h11      = hr_t[0] && (hr_u == 4'd1);
        h12      = hr_t[0] && (hr_u == 4'd2);
        h09      = !hr_t[0] && (hr_u == 4'd9);
        c_ten    = tenth && (ten_q == 4'd9);
        c_sec    = c_ten && (sec_t == 3'd5) && (sec_u == 4'd9);
        c_min    = c_sec && (min_t == 3'd5) && (min_u == 4'd9);
        c_hr     = c_min && (mode24 ? h_last24 : (h11 && hr_t[3]));
        c_day    = c_hr && day_last;
        c_mon    = c_day && mon_t && (mon_u == 4'd2);
        digit_ok = (wdata <= 4'd9);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ten_q <= '0; sec_u <= '0; sec_t <= '0; min_u <= '0; min_t <= '0;
            hr_u  <= '0; hr_t  <= '0; day_u <= 4'd1; day_t <= '0;
            mon_u <= 4'd1; mon_t <= 1'b0; yr_u <= '0; yr_t <= '0;
            wday  <= 3'd1; mode24 <= 1'b1; leap <= 2'b00;
        end else begin
            if (clr_tenths)  ten_q <= '0;
            else if (tenth)  ten_q <= (ten_q == 4'd9) ? 4'd0 : ten_q + 4'd1;

            if (c_ten) begin
                if (sec_u == 4'd9) begin
                    sec_u <= '0;
                    sec_t <= (sec_t == 3'd5) ? 3'd0 : sec_t + 3'd1;
                end else sec_u <= sec_u + 4'd1;
            end

            if (c_sec) begin
                if (min_u == 4'd9) begin
                    min_u <= '0;
                    min_t <= (min_t == 3'd5) ? 3'd0 : min_t + 3'd1;
                end else min_u <= min_u + 4'd1;
            end

            if (c_min) begin
                if (mode24) begin
                    if (h_last24)            begin hr_u <= '0; hr_t <= '0; end
                    else if (hr_u == 4'd9)   begin hr_u <= '0; hr_t <= hr_t + 4'd1; end
                    else                           hr_u <= hr_u + 4'd1;
                end else begin
                    if (h11)      begin hr_u <= 4'd2; hr_t <= {~hr_t[3], 3'b001}; end
                    else if (h12) begin hr_u <= 4'd1; hr_t <= {hr_t[3], 3'b000}; end
                    else if (h09) begin hr_u <= 4'd0; hr_t <= {hr_t[3], 3'b001}; end
                    else                hr_u <= hr_u + 4'd1;
                end
            end

            if (c_hr) begin
                wday <= (wday == 3'd7) ? 3'd1 : wday + 3'd1;
                if (day_last)            begin day_u <= 4'd1; day_t <= '0; end
                else if (day_u == 4'd9)  begin day_u <= '0; day_t <= day_t + 2'd1; end
                else                           day_u <= day_u + 4'd1;
            end

            if (c_day) begin
                if (mon_t && mon_u == 4'd2) begin mon_u <= 4'd1; mon_t <= 1'b0; end
                else if (mon_u == 4'd9)     begin mon_u <= 4'd0; mon_t <= 1'b1; end
                else                              mon_u <= mon_u + 4'd1;
            end

            if (c_mon) begin
                if (yr_u == 4'd9) begin
                    yr_u <= '0;
                    yr_t <= (yr_t == 4'd9) ? 4'd0 : yr_t + 4'd1;
                end else yr_u <= yr_u + 4'd1;
            end

            if (wr_set) begin
                mode24 <= wdata[0];
                leap   <= wdata[3:2];
            end else if (c_mon) begin
                leap   <= leap + 2'd1;
            end

            if (wr_time) begin
                case (waddr)
                    A_SEC_U: if (digit_ok) sec_u <= wdata;
                    A_SEC_T: sec_t <= wdata[2:0];
                    A_MIN_U: if (digit_ok) min_u <= wdata;
                    A_MIN_T: min_t <= wdata[2:0];
                    A_HR_U:  if (digit_ok) hr_u <= wdata;
                    A_HR_T:  hr_t <= mode24 ? {2'b00, wdata[1:0]} : {wdata[3], 2'b00, wdata[0]};
                    A_DAY_U: if (digit_ok) day_u <= wdata;
                    A_DAY_T: day_t <= wdata[1:0];
                    A_MON_U: if (digit_ok) mon_u <= wdata;
                    A_MON_T: mon_t <= wdata[0];
                    A_YR_U:  if (digit_ok) yr_u <= wdata;
                    A_YR_T:  if (digit_ok) yr_t <= wdata;
                    A_WDAY:  wday <= wdata[2:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (raddr)
            A_TENTH: rdata = ten_q;
            A_SEC_U: rdata = sec_u;
            A_SEC_T: rdata = {1'b0, sec_t};
            A_MIN_U: rdata = min_u;
            A_MIN_T: rdata = {1'b0, min_t};
            A_HR_U:  rdata = hr_u;
            A_HR_T:  rdata = hr_t;
            A_DAY_U: rdata = day_u;
            A_DAY_T: rdata = {2'b00, day_t};
            A_MON_U: rdata = mon_u;
            A_MON_T: rdata = {3'b000, mon_t};
            A_YR_U:  rdata = yr_u;
            A_YR_T:  rdata = yr_t;
            A_WDAY:  rdata = {1'b0, wday};
            A_SHARE: rdata = {leap, 1'b0, mode24};
            default: rdata = 4'h0;
        endcase
    end
endmodule

// File: rtl/rtc_irq_timer.sv
module rtc_irq_timer
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tenth,
    input  logic       enable,
    input  logic       code_we,
    input  logic [2:0] code_in,
    input  logic       ack,
    output logic [2:0] code,
    output logic       irq
);
    logic [9:0] cnt_q, span;
    logic       fire, idle;

    always_comb begin
        span = irq_interval(code);
        idle = !enable || (span == 10'd0);
        fire = tenth && !idle && (cnt_q == span - 10'd1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code  <= '0;
            cnt_q <= '0;
            irq   <= 1'b0;
        end else begin
            if (code_we) code <= code_in;
            if (code_we || idle) cnt_q <= '0;
            else if (tenth)      cnt_q <= fire ? 10'd0 : cnt_q + 10'd1;
            if (fire)     irq <= 1'b1;
            else if (ack) irq <= 1'b0;
        end
    end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_pkg::*;
#(
    parameter int TENTH_DIV = 3277
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_32k,
    input  logic [3:0] addr,
    input  logic [3:0] wdata,
    input  logic       wr,
    input  logic       rd,
    output logic [3:0] rdata,
    output logic       irq
);
    clk_state_t state_q, state_d;
    logic test_q, isel_q, istop_q, dchg_q;
    logic run, start, ctrl_wr, ctrl_rd, time_we, set_we, code_we, tenth;
    logic [3:0] cal_rdata;
    logic [2:0] code;

    assign ctrl_wr = wr && (addr == A_CTRL);
    assign ctrl_rd = rd && (addr == A_CTRL);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CLK_HALTED:  if (ctrl_wr && !wdata[2]) state_d = CLK_RUNNING;
            CLK_RUNNING: if (ctrl_wr &&  wdata[2]) state_d = CLK_HALTED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CLK_HALTED;
        else        state_q <= state_d;
    end

    always_comb begin
        run     = (state_q == CLK_RUNNING);
        start   = (state_q == CLK_HALTED) && (state_d == CLK_RUNNING);
        time_we = wr && (state_q == CLK_HALTED) && (addr != A_CTRL) && (addr != A_SHARE);
        set_we  = wr && (addr == A_SHARE) && !isel_q;
        code_we = wr && (addr == A_SHARE) &&  isel_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_q  <= 1'b0;
            isel_q  <= 1'b0;
            istop_q <= 1'b1;
            dchg_q  <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                test_q  <= wdata[3];
                isel_q  <= wdata[1];
                istop_q <= wdata[0];
            end
            if (tenth)        dchg_q <= 1'b1;
            else if (ctrl_rd) dchg_q <= 1'b0;
        end
    end

    rtc_prescaler #(.TENTH_DIV(TENTH_DIV)) i_presc (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_32k), .run(run),
        .test(test_q), .clr(start), .tenth(tenth)
    );

    rtc_calendar i_cal (
        .clk(clk), .rst_n(rst_n), .tenth(tenth), .clr_tenths(start),
        .wr_time(time_we), .wr_set(set_we), .waddr(addr), .wdata(wdata),
        .raddr(addr), .rdata(cal_rdata)
    );

    rtc_irq_timer i_irq (
        .clk(clk), .rst_n(rst_n), .tenth(tenth), .enable(!istop_q),
        .code_we(code_we), .code_in(wdata[2:0]), .ack(ctrl_rd),
        .code(code), .irq(irq)
    );

    always_comb begin
        if (addr == A_CTRL)                rdata = {dchg_q, 3'b000};
        else if (addr == A_SHARE && isel_q) rdata = {1'b0, code};
        else                               rdata = cal_rdata;
    end
endmodule

// File: rtl/rtc_regfile_sva.sv
module rtc_regfile_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       rd,
    input logic [3:0] addr,
    input logic       run,
    input logic       tenth,
    input logic       dchg,
    input logic       irq
);
    // R7: the prescaler never ticks while the state machine is halted
    a_r7_no_tick_halted: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tenth);

    // R2: a tick always leaves the flag set, even against a control read
    a_r2_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        tenth |=> dchg);

    // R2: a control read without a tick clears the flag
    a_r2_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == 4'h0 && !tenth) |=> !dchg);

    // R12: an asserted interrupt holds until a control read
    a_r12_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(rd && addr == 4'h0)) |=> irq);

    // R12: the interrupt only rises on a tenth tick
    a_r12_irq_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(tenth));
endmodule

bind rtc_regfile rtc_regfile_sva i_sva (
    .clk(clk), .rst_n(rst_n), .rd(rd), .addr(addr), .run(run),
    .tenth(tenth), .dchg(dchg_q), .irq(irq)
);

// File: tb/test_rtc_regfile.sv
`timescale 1ns/1ps
module test_rtc_regfile;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_32k = 1'b0;
    logic [3:0] addr = '0;
    logic [3:0] wdata = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic       probe = 1'b0;
    logic [3:0] rdata;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;
    item_t sbq[$];

    always #10 clk = ~clk;

    rtc_regfile #(.TENTH_DIV(5)) i_rtc_regfile (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .addr(addr),
        .wdata(wdata), .wr(wr), .rd(rd), .rdata(rdata), .irq(irq)
    );

    task automatic wr_reg(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [3:0] e, input string tag);
        item_t it;
        @(negedge clk); addr = a; rd = 1'b1;
        it.exp = e; it.tag = tag; sbq.push_back(it);
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic irq_chk(input logic e, input string tag);
        item_t it;
        @(negedge clk); probe = 1'b1;
        it.exp = {3'b000, e}; it.tag = tag; sbq.push_back(it);
        @(negedge clk); probe = 1'b0;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            @(negedge clk); tick_32k = 1'b1;
            repeat (n) @(negedge clk);
            tick_32k = 1'b0;
        end
    endtask

    task automatic load_time(input logic [3:0] ht, input logic [3:0] hu,
                             input logic [3:0] dt, input logic [3:0] du,
                             input logic [3:0] mt, input logic [3:0] mu);
        wr_reg(4'h7, ht); wr_reg(4'h6, hu);
        wr_reg(4'h5, 4'd5); wr_reg(4'h4, 4'd9);
        wr_reg(4'h3, 4'd5); wr_reg(4'h2, 4'd9);
        wr_reg(4'h9, dt); wr_reg(4'h8, du);
        wr_reg(4'hB, mt); wr_reg(4'hA, mu);
    endtask

    // monitor: pops one expected item per probed cycle
    initial begin
        item_t it;
        logic [3:0] act;
        forever begin
            @(negedge clk); #5;
            if (rd || probe) begin
                act = probe ? {3'b000, irq} : rdata;
                if (sbq.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL scoreboard empty: actual %0h expected none", act);
                end else begin
                    it = sbq.pop_front();
                    n_cmp++;
                    if (act !== it.exp) begin
                        n_bad++;
                        $display("FAIL %s: actual %0h expected %0h", it.tag, act, it.exp);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        rd_chk(4'h0, 4'h0, "R1 control after reset");
        rd_chk(4'h6, 4'h0, "R1 hours units");
        rd_chk(4'h8, 4'h1, "R1 day units");
        rd_chk(4'hA, 4'h1, "R1 month units");
        rd_chk(4'hE, 4'h1, "R1 weekday");
        rd_chk(4'hF, 4'h1, "R1 R5 setting 24h");
        irq_chk(1'b0, "R1 irq low");

        // R6 write masking and rejection while halted
        wr_reg(4'h3, 4'hF); rd_chk(4'h3, 4'h7, "R6 seconds tens mask");
        wr_reg(4'h2, 4'hA); rd_chk(4'h2, 4'h0, "R6 units >9 ignored");
        wr_reg(4'h1, 4'h5); rd_chk(4'h1, 4'h0, "R6 tenths write ignored");

        // R10 leap February: 28 Feb 23:59:59, leap phase 00
        wr_reg(4'hF, 4'h1);
        load_time(4'h2, 4'h3, 4'h2, 4'h8, 4'h0, 4'h2);
        wr_reg(4'hD, 4'h2); wr_reg(4'hC, 4'h4); wr_reg(4'hE, 4'h7);
        wr_reg(4'h0, 4'h9);
        rd_chk(4'h1, 4'h0, "R3 tenths cleared at start");
        ticks(9);
        rd_chk(4'h1, 4'h9, "R8 tenths at 9");
        rd_chk(4'h0, 4'h8, "R2 flag set by ticks");
        rd_chk(4'h0, 4'h0, "R2 flag cleared by read");
        ticks(1);
        rd_chk(4'h1, 4'h0, "R8 tenths wrap");
        rd_chk(4'h3, 4'h0, "R8 seconds tens wrap");
        rd_chk(4'h4, 4'h0, "R8 minutes wrap");
        rd_chk(4'h7, 4'h0, "R8 hours tens 23->00");
        rd_chk(4'h6, 4'h0, "R8 hours units 23->00");
        rd_chk(4'h9, 4'h2, "R10 leap day tens");
        rd_chk(4'h8, 4'h9, "R10 leap day 29");
        rd_chk(4'hA, 4'h2, "R10 still February");
        rd_chk(4'hE, 4'h1, "R11 weekday 7->1");

        // R6 write dropped while running
        wr_reg(4'h2, 4'h5); rd_chk(4'h2, 4'h0, "R6 write while running ignored");

        // R2 tick between digit reads
        rd_chk(4'h0, 4'h8, "R2 flag from rollover");
        rd_chk(4'h2, 4'h0, "R2 read seconds units");
        ticks(1);
        rd_chk(4'h3, 4'h0, "R2 read seconds tens");
        rd_chk(4'h0, 4'h8, "R2 retry flag set");
        rd_chk(4'h0, 4'h0, "R2 retry flag cleared");

        // R10 common-year February
        wr_reg(4'h0, 4'h5);
        wr_reg(4'hF, 4'h5); rd_chk(4'hF, 4'h5, "R5 leap phase readback");
        load_time(4'h2, 4'h3, 4'h2, 4'h8, 4'h0, 4'h2);
        wr_reg(4'h0, 4'h9); ticks(10);
        rd_chk(4'h9, 4'h0, "R10 28 Feb common -> day tens 0");
        rd_chk(4'h8, 4'h1, "R10 28 Feb common -> day 1");
        rd_chk(4'hA, 4'h3, "R10 March");

        // R11 year wrap and leap phase advance
        wr_reg(4'h0, 4'h5);
        wr_reg(4'hF, 4'hD);
        load_time(4'h2, 4'h3, 4'h3, 4'h1, 4'h1, 4'h2);
        wr_reg(4'hD, 4'h9); wr_reg(4'hC, 4'h9);
        wr_reg(4'h0, 4'h9); ticks(10);
        rd_chk(4'hD, 4'h0, "R11 year tens wrap");
        rd_chk(4'hC, 4'h0, "R11 year units wrap");
        rd_chk(4'hB, 4'h0, "R10 month tens 12->01");
        rd_chk(4'hA, 4'h1, "R10 month units 12->01");
        rd_chk(4'h8, 4'h1, "R10 day 31->01");
        rd_chk(4'hF, 4'h1, "R11 leap phase 11->00");

        // R9 12-hour mode
        wr_reg(4'h0, 4'h5);
        wr_reg(4'hF, 4'h8);
        wr_reg(4'h7, 4'h1); wr_reg(4'h6, 4'h1);
        wr_reg(4'h5, 4'd5); wr_reg(4'h4, 4'd9); wr_reg(4'h3, 4'd5); wr_reg(4'h2, 4'd9);
        wr_reg(4'h0, 4'h9); ticks(10);
        rd_chk(4'h7, 4'h9, "R9 11 AM -> 12 PM tens");
        rd_chk(4'h6, 4'h2, "R9 11 AM -> 12 PM units");
        wr_reg(4'h0, 4'h5);
        wr_reg(4'h5, 4'd5); wr_reg(4'h4, 4'd9); wr_reg(4'h3, 4'd5); wr_reg(4'h2, 4'd9);
        wr_reg(4'h0, 4'h9); ticks(10);
        rd_chk(4'h7, 4'h8, "R9 12 PM -> 01 PM tens");
        rd_chk(4'h6, 4'h1, "R9 12 PM -> 01 PM units");
        wr_reg(4'h0, 4'h5);
        wr_reg(4'h7, 4'h9); wr_reg(4'h6, 4'h1);
        wr_reg(4'h5, 4'd5); wr_reg(4'h4, 4'd9); wr_reg(4'h3, 4'd5); wr_reg(4'h2, 4'd9);
        wr_reg(4'h0, 4'h9); ticks(10);
        rd_chk(4'h7, 4'h1, "R9 11 PM -> 12 AM tens");
        rd_chk(4'h6, 4'h2, "R9 11 PM -> 12 AM units");
        rd_chk(4'h8, 4'h2, "R9 day advanced at midnight");

        // R7 prescaler in normal mode, divide by 5
        wr_reg(4'h0, 4'h5);
        wr_reg(4'h0, 4'h1);
        ticks(4);
        rd_chk(4'h1, 4'h0, "R7 no tick after 4 enables");
        ticks(1);
        rd_chk(4'h1, 4'h1, "R7 tick on 5th enable");
        rd_chk(4'h0, 4'h8, "R2 clear before irq test");

        // R12 periodic interrupt, R4 shared address
        wr_reg(4'h0, 4'hA);
        rd_chk(4'hF, 4'h0, "R4 interrupt code view");
        wr_reg(4'hF, 4'h1);
        ticks(1);
        irq_chk(1'b1, "R12 irq at 0.1 s");
        ticks(3);
        irq_chk(1'b1, "R12 irq held");
        rd_chk(4'h0, 4'h8, "R12 ack read");
        irq_chk(1'b0, "R12 irq cleared by control read");
        wr_reg(4'hF, 4'h3);
        ticks(9);
        irq_chk(1'b0, "R12 1 s not yet");
        ticks(1);
        irq_chk(1'b1, "R12 1 s reached");
        rd_chk(4'h0, 4'h8, "R12 ack 1 s");
        wr_reg(4'hF, 4'h0);
        ticks(20);
        irq_chk(1'b0, "R12 code 0 disables");
        wr_reg(4'hF, 4'h1);
        wr_reg(4'h0, 4'hB);
        ticks(3);
        irq_chk(1'b0, "R12 interrupt stop");
        wr_reg(4'h0, 4'h8);
        rd_chk(4'hF, 4'h8, "R4 setting unchanged by code writes");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule